// File: doc/BRIEF.md
# Serial Transmit Sequencer with CRC Trailer

This block sequences one outgoing frame on a serial transmit path. Each word of user data comes from a transmit queue that sits outside the block. The word is loaded into a 16-bit shift register and handed to a phase encoder one bit at a time, most significant bit first. The encoder confirms that it has taken each bit with a strobe that lasts one cycle. Each confirmed bit makes the block pulse a clock enable for an external serial CRC generator.

A frame starts with a single synchronising one bit, the mark. The user words follow. After the last bit of the last word the block switches the encoder's input over to the CRC output and sends the 16 check bits. The shift register fills with zeros while it shifts, so its output can be ORed with the CRC output during the trailer without corrupting it. A single-cycle state between the data and the trailer winds the bit counter back by one. Because of this, the counter reports empty one bit before the trailer ends. The sequencer can then drop the encoder enable early and wait for the final acknowledge. An abort returns the sequencer to idle from any state.

Top module: `tx_seq_top`

## Requirements
- R1: After a synchronous reset, enc_go_o, enc_bit_o, crc_sel_o, crc_clk_o and done_o are 0 and sr_ctrl_o is 2'b11 (hold).
- R2: While abort_i is high at a clock edge, the sequencer goes idle (enc_go_o and crc_sel_o low from the next cycle), and done_o is high in the cycle after each such edge.
- R3: When idle, start_i high at an edge moves the sequencer to the mark state. In the mark state enc_go_o is 1 and enc_bit_o is 1. start_i is ignored in every other state.
- R4: An acknowledge (bit_ack_i high) taken in the mark, data or CRC state gives crc_clk_o = 1 for exactly the next cycle. In the mark state the same acknowledge also loads word_i into the shift register and moves the sequencer to the data state.
- R5: In the data state, enc_bit_o shows the loaded word most significant bit first. Each acknowledge advances it by one bit. The acknowledge of the 16th bit loads the next word_i, unless stop_i is high at that edge.
- R6: An acknowledge of the 16th bit with stop_i high shifts the register and enters a pre-trailer state. That state lasts exactly one cycle, shifts once more, and raises crc_sel_o, which stays high until the sequencer returns to idle.
- R7: In the CRC state the 15th acknowledge drops enc_go_o and enters the final state, with crc_sel_o still high.
- R8: In the final state, an acknowledge returns the sequencer to idle and done_o is high for exactly one cycle.
- R9: The shift register fills with zeros, so enc_bit_o is 0 whenever crc_sel_o is 1.
- R10: sr_ctrl_o shows the shift-register action taken at the previous edge, coded load = 2'b00, shift = 2'b10, hold = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start condition (queue ready and line quiet) |
| stop_i | input | 1 | Last word of the frame is in the shift register |
| abort_i | input | 1 | Abort the frame and return to idle |
| bit_ack_i | input | 1 | One-cycle strobe from the encoder: bit taken |
| word_i | input | 16 | Next data word from the transmit queue |
| enc_go_o | output | 1 | Encoder enable |
| enc_bit_o | output | 1 | Serial data bit (mark OR shift register MSB) |
| crc_sel_o | output | 1 | Select the CRC output as the serial source |
| crc_clk_o | output | 1 | One-cycle clock enable for the CRC generator |
| sr_ctrl_o | output | 2 | Shift action taken at the previous edge |
| done_o | output | 1 | Frame finished or aborted |

## Verification
The assertions assume that bit_ack_i is a strobe and is never high in two consecutive cycles. They also assume that stop_i is only meaningful when the shift register is about to become empty, which makes the all-zero trailer of R9 hold. The random stimulus keeps to this. It never raises the acknowledge in the cycle right after an acknowledge, and it raises abort rarely, so that frames often run to completion. Directed frames hold stop_i high throughout, so that the trailer is reached after exactly one word.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MARK = 3'd1,
    ST_DATA = 3'd2,
    ST_PRE  = 3'd3,
    ST_CRC  = 3'd4,
    ST_POST = 3'd5
  } tx_state_e;

  typedef enum logic [1:0] {
    SR_LOAD  = 2'b00,
    SR_SHIFT = 2'b10,
    SR_HOLD  = 2'b11
  } sr_ctrl_e;
endpackage

// File: rtl/tx_seq_shreg.sv
module tx_seq_shreg
  import tx_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  sr_ctrl_e     ctl_i,
  input  logic [W-1:0] word_i,
  output logic         msb_o,
  output logic         empty_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (ctl_i)
        SR_LOAD: begin
          sr_q  <= word_i;
          cnt_q <= LAST;
        end
        SR_SHIFT: begin
          sr_q  <= {sr_q[W-2:0], 1'b0};
          cnt_q <= (cnt_q == '0) ? LAST : cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign msb_o   = sr_q[W-1];
  assign empty_o = (cnt_q == '0);

  assert_zero_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == SR_SHIFT) |=> (sr_q[0] == 1'b0));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == SR_HOLD) |=> ($stable(sr_q) && $stable(cnt_q)));
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      abort_i,
  input  logic      ack_i,
  input  logic      empty_i,
  output tx_state_e state_o,
  output sr_ctrl_e  ctl_o,
  output logic      crc_clk_o,
  output logic      done_o,
  output logic [1:0] sr_ctrl_o
);
  tx_state_e state_q, nxt;
  sr_ctrl_e  ctl;
  logic      cclk, done_c;

  always_comb begin
    nxt    = state_q;
    ctl    = SR_HOLD;
    cclk   = 1'b0;
    done_c = abort_i;
    if (abort_i) begin
      nxt = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) nxt = ST_MARK;
        ST_MARK: if (ack_i) begin
          nxt  = ST_DATA;
          cclk = 1'b1;
          ctl  = SR_LOAD;
        end
        ST_DATA: if (ack_i) begin
          cclk = 1'b1;
          ctl  = SR_SHIFT;
          if (empty_i) begin
            ctl = SR_LOAD;
            if (stop_i) begin
              ctl = SR_SHIFT;
              nxt = ST_PRE;
            end
          end
        end
        ST_PRE: begin
          ctl = SR_SHIFT;
          nxt = ST_CRC;
        end
        ST_CRC: if (ack_i) begin
          cclk = 1'b1;
          ctl  = SR_SHIFT;
          if (empty_i) nxt = ST_POST;
        end
        ST_POST: if (ack_i) begin
          done_c = 1'b1;
          nxt    = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      crc_clk_o <= 1'b0;
      done_o    <= 1'b0;
      sr_ctrl_o <= SR_HOLD;
    end else begin
      state_q   <= nxt;
      crc_clk_o <= cclk;
      done_o    <= done_c;
      sr_ctrl_o <= ctl;
    end
  end

  assign state_o = state_q;
  assign ctl_o   = ctl;

  assert_abort_idle_R2: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (state_q == ST_IDLE && done_o));

  assert_mark_load_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MARK && ack_i && !abort_i) |=>
      (state_q == ST_DATA && sr_ctrl_o == SR_LOAD && crc_clk_o));

  assert_clk_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    crc_clk_o |-> $past(ack_i));

  assert_pre_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRE && !abort_i) |=> (state_q == ST_CRC));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_POST && ack_i && !abort_i) |=> (done_o && state_q == ST_IDLE));
endmodule

// File: rtl/tx_seq_top.sv
module tx_seq_top
  import tx_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         abort_i,
  input  logic         bit_ack_i,
  input  logic [W-1:0] word_i,
  output logic         enc_go_o,
  output logic         enc_bit_o,
  output logic         crc_sel_o,
  output logic         crc_clk_o,
  output logic [1:0]   sr_ctrl_o,
  output logic         done_o
);
  tx_state_e state;
  sr_ctrl_e  ctl;
  logic      msb, empty;

  tx_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .abort_i   (abort_i),
    .ack_i     (bit_ack_i),
    .empty_i   (empty),
    .state_o   (state),
    .ctl_o     (ctl),
    .crc_clk_o (crc_clk_o),
    .done_o    (done_o),
    .sr_ctrl_o (sr_ctrl_o)
  );

  tx_seq_shreg #(.W(W)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .ctl_i   (ctl),
    .word_i  (word_i),
    .msb_o   (msb),
    .empty_o (empty)
  );

  assign enc_go_o  = (state == ST_MARK) || (state == ST_DATA) ||
                     (state == ST_PRE)  || (state == ST_CRC);
  assign crc_sel_o = (state == ST_PRE) || (state == ST_CRC) || (state == ST_POST);
  assign enc_bit_o = (state == ST_MARK) | msb;

  assert_trailer_zero_R9: assert property (@(posedge clk) disable iff (rst)
    crc_sel_o |-> !enc_bit_o);

  assert_go_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (crc_sel_o && !enc_go_o && !abort_i && !bit_ack_i) |=> (crc_sel_o && !enc_go_o));
endmodule

// File: tb/tx_seq_top_bench.sv
`timescale 1ns/100ps
module tx_seq_top_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0, abort_i = 1'b0, bit_ack_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic enc_go_o, enc_bit_o, crc_sel_o, crc_clk_o, done_o;
  logic [1:0] sr_ctrl_o;

  int nchk = 0, nfail = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_seq_top #(.W(W)) u_tx_seq_top (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .abort_i(abort_i), .bit_ack_i(bit_ack_i), .word_i(word_i),
    .enc_go_o(enc_go_o), .enc_bit_o(enc_bit_o), .crc_sel_o(crc_sel_o),
    .crc_clk_o(crc_clk_o), .sr_ctrl_o(sr_ctrl_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements: 0 idle,1 mark,2 data,3 pre,4 crc,5 post
  int m_st = 0, m_cnt = 0;
  logic [W-1:0] m_sr = '0;
  logic m_cclk = 0, m_done = 0;
  logic [1:0] m_ctl = 2'b11;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_sr = '0; m_cclk = 0; m_done = 0; m_ctl = 2'b11;
    end else begin
      int nx;
      logic [1:0] c;
      logic ck, dn;
      nx = m_st; c = 2'b11; ck = 0; dn = abort_i;
      if (abort_i) nx = 0;
      else if (m_st == 0 && start_i) nx = 1;
      else if (m_st == 1 && bit_ack_i) begin nx = 2; ck = 1; c = 2'b00; end
      else if (m_st == 2 && bit_ack_i) begin
        ck = 1;
        if (m_cnt != 0) c = 2'b10;
        else if (stop_i) begin c = 2'b10; nx = 3; end
        else c = 2'b00;
      end
      else if (m_st == 3) begin c = 2'b10; nx = 4; end
      else if (m_st == 4 && bit_ack_i) begin ck = 1; c = 2'b10; if (m_cnt == 0) nx = 5; end
      else if (m_st == 5 && bit_ack_i) begin dn = 1; nx = 0; end
      if (c == 2'b00) begin m_sr = word_i; m_cnt = W - 1; end
      else if (c == 2'b10) begin
        m_sr = m_sr << 1;
        m_cnt = (m_cnt == 0) ? W - 1 : m_cnt - 1;
      end
      m_st = nx; m_cclk = ck; m_done = dn; m_ctl = c;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 enc_go", enc_go_o, (m_st >= 1 && m_st <= 4));
      chk("R6 crc_sel", crc_sel_o, (m_st >= 3 && m_st <= 5));
      chk("R5 enc_bit", enc_bit_o, (m_st == 1) | m_sr[W-1]);
      chk("R4 crc_clk", crc_clk_o, m_cclk);
      chk("R8 done", done_o, m_done);
      chk("R10 sr_ctrl", sr_ctrl_o, m_ctl);
    end
  end

  task automatic ack_pulse();
    @(negedge clk) bit_ack_i = 1'b1;
    @(negedge clk) bit_ack_i = 1'b0;
  endtask

  task automatic run_frame(input logic [W-1:0] w);
    @(negedge clk) begin start_i = 1'b1; word_i = w; stop_i = 1'b1; end
    @(negedge clk) start_i = 1'b0;
    chk("R3 mark go", enc_go_o, 1);
    chk("R3 mark bit", enc_bit_o, 1);
    ack_pulse();
    chk("R4 clk after mark ack", crc_clk_o, 1);
    chk("R10 load code", sr_ctrl_o, 2'b00);
    for (int i = 0; i < W; i++) begin
      chk("R5 data bit order", enc_bit_o, w[W-1-i]);
      ack_pulse();
      if (i == 0) chk("R10 shift code", sr_ctrl_o, 2'b10);
    end
    chk("R6 pre sel", crc_sel_o, 1);
    chk("R6 pre go", enc_go_o, 1);
    chk("R9 pre bit zero", enc_bit_o, 0);
    @(negedge clk);
    chk("R10 pre shifted", sr_ctrl_o, 2'b10);
    for (int k = 1; k <= 15; k++) begin
      ack_pulse();
      chk("R9 trailer bit zero", enc_bit_o, 0);
      chk("R7 go during trailer", enc_go_o, (k < 15));
    end
    chk("R7 sel in final", crc_sel_o, 1);
    ack_pulse();
    chk("R8 done pulse", done_o, 1);
    chk("R8 back idle", crc_sel_o, 0);
    @(negedge clk);
    chk("R8 done one cycle", done_o, 0);
    stop_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    chk("R1 go", enc_go_o, 0);
    chk("R1 bit", enc_bit_o, 0);
    chk("R1 sel", crc_sel_o, 0);
    chk("R1 clk", crc_clk_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 ctrl", sr_ctrl_o, 2'b11);

    run_frame(16'hA5C3);
    run_frame(16'h8001);

    // R2 abort in the middle of data
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    ack_pulse();
    ack_pulse();
    @(negedge clk) abort_i = 1'b1;
    @(negedge clk);
    chk("R2 idle after abort", enc_go_o, 0);
    chk("R2 done during abort", done_o, 1);
    @(negedge clk) abort_i = 1'b0;
    chk("R2 done held", done_o, 1);
    @(negedge clk);
    chk("R2 done released", done_o, 0);

    // random phase
    begin
      logic prev_ack;
      prev_ack = 1'b0;
      for (int n = 0; n < 4000; n++) begin
        @(negedge clk);
        bit_ack_i = !prev_ack && ($urandom % 3 == 0);
        prev_ack  = bit_ack_i;
        start_i   = ($urandom % 4 == 0);
        stop_i    = ($urandom % 6 == 0);
        abort_i   = ($urandom % 200 == 0);
        word_i    = W'($urandom);
      end
    end
    @(negedge clk) begin bit_ack_i = 0; start_i = 0; stop_i = 0; abort_i = 0; end
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule